// File: doc/BRIEF.md
# Thermal Derating Scaler

This block turns a temperature-sense reading into a brightness scale factor for an LED driver. An ADC delivers a code once per AC half cycle, together with a one-cycle strobe. The block places the code in one of four bands. A warm-enough reading gives full brightness. A band just below it derates brightness linearly. Below that band the output holds at a 10% floor. Below the lowest threshold the block raises a shutdown fault.

The scale output is an 8-bit fraction of full scale, where 255 means 100%. It changes only on an accepted strobe. The fault output is latched and is meant to hold the rest of the controller in reset until the block itself is reset at power-on. All thresholds are parameters given as ADC codes. The defaults assume a 10-bit converter on a 2.5 V reference: 0.1 V is code 41, 0.3 V is code 123 and 0.5 V is code 205. The ramp uses one constant multiply and a right shift, with no divider.

Top module: `tdr_thermal_derate`

## Requirements
- R1: After synchronous reset, `scale` is 0 and `fault` is 0.
- R2: `scale` and `fault` change only on a clock edge where `sample_stb` is 1. With the strobe low, a new `code` has no effect.
- R3: On a strobe with `code` >= HI_CODE (205), `scale` becomes 255 at that edge. This holds for every code up to the ADC maximum.
- R4: On a strobe with LO_CODE (123) <= `code` < HI_CODE, `scale` becomes FLOOR + (((code - LO_CODE) * K) >> SHIFT). Here FLOOR = 26, SHIFT = 8, and K = round(229 * 2^SHIFT / (HI_CODE - LO_CODE)) = 715.
- R5: On a strobe with SHUT_CODE (41) <= `code` < LO_CODE, `scale` becomes FLOOR (26).
- R6: On a strobe with `code` < SHUT_CODE, `fault` becomes 1 and `scale` becomes 0 at that edge.
- R7: Once `fault` is 1, it stays 1 and `scale` stays 0 until reset, whatever codes are strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | One-cycle strobe at each half-cycle sample |
| code | input | 10 | ADC code of the sense voltage |
| scale | output | 8 | Brightness fraction, 255 = full |
| fault | output | 1 | Latched thermal shutdown |

## Verification
Both results are registered at the edge that sees the strobe, so each one is due one edge after the strobe is driven. The monitor notices the strobe at that rising edge and compares at the falling edge that follows. Hold behaviour is checked on the falling edges of strobe-free cycles, after a code that would have faulted had it been taken. The whole ramp band is swept code by code against a table that the bench computes with its own arithmetic.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  typedef enum logic [1:0] {
    RG_NORMAL = 2'd0,
    RG_RAMP   = 2'd1,
    RG_FLOOR  = 2'd2,
    RG_SHUT   = 2'd3
  } region_t;

  // Fixed-point slope: span_out / span_in scaled by 2^sh, rounded to nearest.
  function automatic int unsigned ramp_slope(input int unsigned span_out,
                                             input int unsigned span_in,
                                             input int unsigned sh);
    return ((span_out << sh) + span_in / 2) / span_in;
  endfunction

  // Width that can hold the value v.
  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned n;
    n = 1;
    while ((v >> n) != 0) n++;
    return n;
  endfunction

endpackage

// File: rtl/tdr_classify.sv
module tdr_classify
  import tdr_pkg::*;
#(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned SHUT_CODE = 41,
  parameter int unsigned LO_CODE   = 123,
  parameter int unsigned HI_CODE   = 205
) (
  input  logic [ADC_W-1:0] code,
  output region_t          region
);

  localparam logic [ADC_W-1:0] SHUT_Q = ADC_W'(SHUT_CODE);
  localparam logic [ADC_W-1:0] LO_Q   = ADC_W'(LO_CODE);
  localparam logic [ADC_W-1:0] HI_Q   = ADC_W'(HI_CODE);

  logic below_shut;
  logic below_lo;
  logic below_hi;

  assign below_shut = code < SHUT_Q;
  assign below_lo   = code < LO_Q;
  assign below_hi   = code < HI_Q;

  always_comb begin
    if (below_shut)    region = RG_SHUT;
    else if (below_lo) region = RG_FLOOR;
    else if (below_hi) region = RG_RAMP;
    else               region = RG_NORMAL;
  end

endmodule

// File: rtl/tdr_ramp.sv
module tdr_ramp
  import tdr_pkg::*;
#(
  parameter int unsigned ADC_W   = 10,
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned LO_CODE = 123,
  parameter int unsigned HI_CODE = 205,
  parameter int unsigned FLOOR   = 26,
  parameter int unsigned SHIFT   = 8
) (
  input  logic [ADC_W-1:0]   code,
  output logic [SCALE_W-1:0] ramp_val
);

  localparam int unsigned FULL  = (1 << SCALE_W) - 1;
  localparam int unsigned SPAN  = HI_CODE - LO_CODE;
  localparam int unsigned K     = ramp_slope(FULL - FLOOR, SPAN, SHIFT);
  localparam int unsigned KW    = bits_for(K);
  localparam int unsigned PW    = ADC_W + KW;
  localparam int unsigned SW    = PW + 1;

  localparam logic [ADC_W-1:0] LO_Q   = ADC_W'(LO_CODE);
  localparam logic [ADC_W-1:0] SPAN_Q = ADC_W'(SPAN);
  localparam logic [KW-1:0]    K_Q    = KW'(K);

  logic [ADC_W-1:0] delta;
  logic [PW-1:0]    prod;
  logic [SW-1:0]    sum;

  // Clamp the offset into the ramp span so that out-of-band codes stay bounded.
  always_comb begin
    if (code < LO_Q)                 delta = '0;
    else if (code - LO_Q > SPAN_Q)   delta = SPAN_Q;
    else                             delta = code - LO_Q;
  end

  assign prod = PW'(delta) * PW'(K_Q);
  assign sum  = SW'(FLOOR) + SW'(prod >> SHIFT);

  always_comb begin
    if (sum > SW'(FULL)) ramp_val = SCALE_W'(FULL);
    else                 ramp_val = sum[SCALE_W-1:0];
  end

endmodule

// File: rtl/tdr_thermal_derate.sv
module tdr_thermal_derate
  import tdr_pkg::*;
#(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned SCALE_W   = 8,
  parameter int unsigned SHUT_CODE = 41,
  parameter int unsigned LO_CODE   = 123,
  parameter int unsigned HI_CODE   = 205,
  parameter int unsigned FLOOR     = 26,
  parameter int unsigned SHIFT     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_stb,
  input  logic [ADC_W-1:0]   code,
  output logic [SCALE_W-1:0] scale,
  output logic               fault
);

  localparam logic [SCALE_W-1:0] FULL_Q  = {SCALE_W{1'b1}};
  localparam logic [SCALE_W-1:0] FLOOR_Q = SCALE_W'(FLOOR);

  region_t            region;
  logic [SCALE_W-1:0] ramp_val;
  logic [SCALE_W-1:0] next_scale;
  logic               accept;
  logic               shut_hit;
  logic [SCALE_W-1:0] scale_q;
  logic               fault_q;

  tdr_classify #(
    .ADC_W    (ADC_W),
    .SHUT_CODE(SHUT_CODE),
    .LO_CODE  (LO_CODE),
    .HI_CODE  (HI_CODE)
  ) u_cls (
    .code  (code),
    .region(region)
  );

  tdr_ramp #(
    .ADC_W  (ADC_W),
    .SCALE_W(SCALE_W),
    .LO_CODE(LO_CODE),
    .HI_CODE(HI_CODE),
    .FLOOR  (FLOOR),
    .SHIFT  (SHIFT)
  ) u_ramp (
    .code    (code),
    .ramp_val(ramp_val)
  );

  assign accept   = sample_stb && !fault_q;
  assign shut_hit = accept && (region == RG_SHUT);

  always_comb begin
    unique case (region)
      RG_NORMAL: next_scale = FULL_Q;
      RG_RAMP:   next_scale = ramp_val;
      RG_FLOOR:  next_scale = FLOOR_Q;
      default:   next_scale = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q <= '0;
      fault_q <= 1'b0;
    end else if (accept) begin
      scale_q <= next_scale;
      fault_q <= shut_hit;
    end
  end

  assign scale = scale_q;
  assign fault = fault_q;

endmodule

// File: rtl/tdr_thermal_derate_chk.sv
module tdr_thermal_derate_chk
  import tdr_pkg::*;
#(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned SCALE_W   = 8,
  parameter int unsigned SHUT_CODE = 41,
  parameter int unsigned LO_CODE   = 123,
  parameter int unsigned HI_CODE   = 205,
  parameter int unsigned FLOOR     = 26
) (
  input logic               clk,
  input logic               rst,
  input logic               sample_stb,
  input logic [ADC_W-1:0]   code,
  input logic [SCALE_W-1:0] scale,
  input logic               fault,
  input region_t            region,
  input logic               accept
);

  localparam logic [SCALE_W-1:0] FULL_Q  = {SCALE_W{1'b1}};
  localparam logic [SCALE_W-1:0] FLOOR_Q = SCALE_W'(FLOOR);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ($stable(scale) && $stable(fault)));

  p_full_r3: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !fault && code >= ADC_W'(HI_CODE)) |=> (scale == FULL_Q));

  p_ramp_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && region == RG_RAMP) |=> (scale >= FLOOR_Q && scale < FULL_Q));

  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !fault && code >= ADC_W'(SHUT_CODE) && code < ADC_W'(LO_CODE))
      |=> (scale == FLOOR_Q && !fault));

  p_shut_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !fault && code < ADC_W'(SHUT_CODE)) |=> fault);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    fault |=> (fault && scale == '0));

endmodule

bind tdr_thermal_derate tdr_thermal_derate_chk #(
  .ADC_W    (ADC_W),
  .SCALE_W  (SCALE_W),
  .SHUT_CODE(SHUT_CODE),
  .LO_CODE  (LO_CODE),
  .HI_CODE  (HI_CODE),
  .FLOOR    (FLOOR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_stb(sample_stb),
  .code      (code),
  .scale     (scale),
  .fault     (fault),
  .region    (region),
  .accept    (accept)
);

// File: tb/sim_tdr_thermal_derate.sv
module sim_tdr_thermal_derate;

  localparam int CLK_P = 10;
  localparam int T_SHUT = 41;
  localparam int T_LO = 123;
  localparam int T_HI = 205;
  localparam int T_FLOOR = 26;

  typedef struct {
    int    scale;
    int    fault;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_stb = 1'b0;
  logic [9:0] code = '0;
  logic [7:0] scale;
  logic       fault;

  int checks = 0;
  int errors = 0;
  int m_fault = 0;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  tdr_thermal_derate u0 (
    .clk       (clk),
    .rst       (rst),
    .sample_stb(sample_stb),
    .code      (code),
    .scale     (scale),
    .fault     (fault)
  );

  // Reference: slope is (255 - floor) / span in 1/256 units, rounded; then truncated product.
  function automatic int ref_scale(input int c);
    int k;
    if (c >= T_HI) return 255;
    if (c >= T_LO) begin
      k = ((255 - T_FLOOR) * 256 + (T_HI - T_LO) / 2) / (T_HI - T_LO);
      return T_FLOOR + ((c - T_LO) * k) / 256;
    end
    if (c >= T_SHUT) return T_FLOOR;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int c, input string tag);
    exp_t it;
    @(negedge clk);
    code = 10'(c);
    sample_stb = 1'b1;
    if (m_fault == 0 && c < T_SHUT) m_fault = 1;
    it.fault = m_fault;
    it.scale = (m_fault != 0) ? 0 : ref_scale(c);
    it.tag   = tag;
    sb.push_back(it);
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  // Monitor: result is due at the edge that sees the strobe; compare at the next falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (sample_stb === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          check("scoreboard underflow", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " scale"}, int'(scale), e.scale);
          check({e.tag, " fault"}, int'(fault), e.fault);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset scale", int'(scale), 0);
    check("R1 reset fault", int'(fault), 0);

    send(1023, "R3 top code");
    send(T_HI, "R3 band edge");
    send(600, "R3 mid normal");
    send(T_HI - 1, "R4 ramp top");
    send(T_LO, "R4 ramp bottom");
    send(150, "R4 ramp 150");
    send(T_LO - 1, "R5 floor top");
    send(80, "R5 floor mid");
    send(T_SHUT, "R5 floor bottom");

    // R2: a faulting code without strobe must not be taken.
    @(negedge clk);
    code = 10'd0;
    repeat (3) begin
      @(negedge clk);
      check("R2 hold scale", int'(scale), T_FLOOR);
      check("R2 hold fault", int'(fault), 0);
    end

    for (int c = T_LO; c < T_HI; c++) send(c, "R4 ramp sweep");

    send(T_SHUT - 1, "R6 shutdown edge");
    send(1023, "R7 after fault");
    send(150, "R7 after fault ramp");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_fault = 0;
    @(negedge clk);
    check("R1 re-reset scale", int'(scale), 0);
    check("R1 re-reset fault", int'(fault), 0);
    send(300, "R3 after reset");
    send(0, "R6 zero code");

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule